// File: doc/BRIEF.md
# Level-Programmable Interrupt Priority Controller

The controller watches 64 interrupt request lines and reports to the processor the most urgent pending priority level on a 3-bit output. Software gives every source a priority level from 1 to 7; level 0 parks the source. A source becomes an active request when its raw line or its software force bit is set and its mask bit is clear. Among active requests the highest level wins. Inside one level the higher-numbered source wins. An optional comparison against the processor's current mask level suppresses the output unless the winning level is strictly above that mask.

Software reaches the block through a simple 8-bit register port with one access per cycle. The port has one acknowledge read that covers every level and seven acknowledge reads, one per level. Each acknowledge read returns an interrupt vector, computed as 64 plus the winning source number. If no source qualifies, the read returns a fixed spurious vector.

Top module: `intc_top`

## Requirements
- R1: After reset, irqLevel is 0, regRspValid and regRspErr are 0, and all level, force, mask and control registers read 0.
- R2: The level register of source n sits at address n (0x00–0x3F) and holds data bits 2:0. A read returns those bits with bits 7:3 zero.
- R3: A source is active when (irqReq bit OR force bit) is set and its mask bit is clear. Force byte k sits at 0x40+k and mask byte k at 0x48+k, and bit b of each covers source 8k+b.
- R4: A source whose level register holds 0 is never active, even if it is requested or forced.
- R5: irqLevel carries the highest level among active sources. It is registered, so it follows an input change one clock later and a register write two clocks later.
- R6: The control register at 0x50 holds the masking enable in bit 3 and the processor mask level in bits 2:0. When masking is enabled, irqLevel is the top level if that level is strictly greater than the mask level, and 0 otherwise. When masking is disabled, the mask level has no effect.
- R7: A read of 0x58 returns 64 plus the number of the winning source across all levels: highest level first, then highest source number. Level masking does not affect this read.
- R8: A read of 0x58+n (n = 1..7) returns 64 plus the highest-numbered active source programmed to level n. Sources at other levels are ignored.
- R9: An acknowledge read with no qualifying source returns 0x18.
- R10: A write to any address from 0x58 to 0x5F gives regRspErr high for one cycle with regRspValid low, and changes no state.
- R11: Every read, and every write outside 0x58–0x5F, gives regRspValid high for exactly one cycle, one clock after the request. A read returns its data on regRspData, and a write returns 0. No request means no response. If read and write are both asserted, the write is taken.
- R12: Reads of unmapped addresses (0x51–0x57, 0x60–0x7F) return 0. Writes to them complete normally and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 64 | Raw interrupt request lines, one per source |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| regAddr | input | 7 | Register address |
| regWrData | input | 8 | Write data |
| regRspValid | output | 1 | Normal completion, one cycle after the request |
| regRspErr | output | 1 | Error completion, one cycle after the request |
| regRspData | output | 8 | Read data, valid with regRspValid |
| irqLevel | output | 3 | Registered highest unmasked active level |

## Verification
The bench puts several sources on one level to check the tie rule. A priority encoder that lets the lower number win would return the wrong vector on the level acknowledge. It also sets the processor mask level equal to the top level. A design that compares with greater-or-equal would then assert an interrupt when it should show 0. Other cases are a forced source parked at level 0, which must stay silent, and a per-level acknowledge while a higher level is active, which a design leaking across levels would answer with the other level's vector. Writes to acknowledge addresses must return an error and no normal completion, and unmapped addresses must read as zero. Randomised level maps then compare every acknowledge read and the output level against a reference model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_COUNT  = 64;
  localparam int LVL_W      = 3;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int SRC_IDX_W  = $clog2(SRC_COUNT);
  localparam int BYTE_COUNT = SRC_COUNT / 8;
  localparam int BYTE_IDX_W = $clog2(BYTE_COUNT);
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;

  // address map; bases are multiples of 8 so low address bits index directly
  localparam int FORCE_BASE = SRC_COUNT;
  localparam int MASK_BASE  = FORCE_BASE + BYTE_COUNT;
  localparam int CTRL_ADDR  = MASK_BASE + BYTE_COUNT;
  localparam int ACK_BASE   = CTRL_ADDR + NUM_LVL;

  localparam logic [DATA_W-1:0] VEC_BASE     = DATA_W'(64);
  localparam logic [DATA_W-1:0] VEC_SPURIOUS = DATA_W'(8'h18);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LEVEL, SEL_FORCE, SEL_MASK, SEL_CTRL, SEL_ACK
  } rdSel_e;

  typedef struct packed {
    logic                  wrLevel;
    logic                  wrForce;
    logic                  wrMask;
    logic                  wrCtrl;
    rdSel_e                rdSel;
    logic [SRC_IDX_W-1:0]  srcIdx;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic [LVL_W-1:0]      ackLvl;   // 0 selects the all-level acknowledge
    logic [DATA_W-1:0]     wrData;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_pick.sv
// Returns the highest set index of req.
module intc_pick #(
  parameter int N     = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign hit = |req;
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rdMux,
  output ctlStrobe_t        strobe,
  output logic              regRspValid,
  output logic              regRspErr,
  output logic [DATA_W-1:0] regRspData
);
  localparam logic [ADDR_W-1:0] FORCE_A    = ADDR_W'(FORCE_BASE);
  localparam logic [ADDR_W-1:0] MASK_A     = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] CTRL_A     = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] ACK_A      = ADDR_W'(ACK_BASE);
  localparam logic [ADDR_W-1:0] ACK_LAST_A = ADDR_W'(ACK_BASE + NUM_LVL - 1);

  logic isLevel, isForce, isMask, isCtrl, isAck;
  logic wrOp, rdOp;

  always_comb begin
    isLevel = regAddr < FORCE_A;
    isForce = (regAddr >= FORCE_A) && (regAddr < MASK_A);
    isMask  = (regAddr >= MASK_A) && (regAddr < CTRL_A);
    isCtrl  = regAddr == CTRL_A;
    isAck   = (regAddr >= ACK_A) && (regAddr <= ACK_LAST_A);
    wrOp    = regWrEn;
    rdOp    = regRdEn && !regWrEn;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrLevel = wrOp && isLevel;
    strobe.wrForce = wrOp && isForce;
    strobe.wrMask  = wrOp && isMask;
    strobe.wrCtrl  = wrOp && isCtrl;
    strobe.srcIdx  = regAddr[SRC_IDX_W-1:0];
    strobe.byteIdx = regAddr[BYTE_IDX_W-1:0];
    strobe.ackLvl  = regAddr[LVL_W-1:0];
    strobe.wrData  = regWrData;
    if (!rdOp)        strobe.rdSel = SEL_NONE;
    else if (isLevel) strobe.rdSel = SEL_LEVEL;
    else if (isForce) strobe.rdSel = SEL_FORCE;
    else if (isMask)  strobe.rdSel = SEL_MASK;
    else if (isCtrl)  strobe.rdSel = SEL_CTRL;
    else if (isAck)   strobe.rdSel = SEL_ACK;
    else              strobe.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRspValid <= 1'b0;
      regRspErr   <= 1'b0;
      regRspData  <= '0;
    end else begin
      regRspValid <= rdOp || (wrOp && !isAck);
      regRspErr   <= wrOp && isAck;
      regRspData  <= rdOp ? rdMux : '0;
    end
  end

  // R10
  ack_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr >= ACK_A && regAddr <= ACK_LAST_A) |=> (regRspErr && !regRspValid));

  // R11
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regRspValid && regRspErr));

  // R11
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !regRdEn) |=> (!regRspValid && !regRspErr));

  // R9
  ack_vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr >= ACK_A && regAddr <= ACK_LAST_A) |=>
      (regRspData == VEC_SPURIOUS || regRspData >= VEC_BASE));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] irqReq,
  input  ctlStrobe_t           strobe,
  output logic [DATA_W-1:0]    rdMux,
  output logic [LVL_W-1:0]     irqLevel
);
  logic [LVL_W-1:0]     srcLvlQ [SRC_COUNT];
  logic [SRC_COUNT-1:0] forceQ, maskQ;
  logic                 ctlEnQ;
  logic [LVL_W-1:0]     ctlMaskLvlQ;
  logic [LVL_W-1:0]     irqLevelQ;

  logic [SRC_COUNT-1:0] activeVec;
  logic [NUM_LVL-1:0]   lvlHit;
  logic [SRC_IDX_W-1:0] lvlWin [NUM_LVL];
  logic                 topValid;
  logic [LVL_W-1:0]     topLvl;
  logic [SRC_IDX_W-1:0] swIdx;
  logic [LVL_W-1:0]     irqNext;

  // register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SRC_COUNT; i++) srcLvlQ[i] <= '0;
      forceQ      <= '0;
      maskQ       <= '0;
      ctlEnQ      <= 1'b0;
      ctlMaskLvlQ <= '0;
    end else begin
      if (strobe.wrLevel) srcLvlQ[strobe.srcIdx] <= strobe.wrData[LVL_W-1:0];
      if (strobe.wrForce) forceQ[int'(strobe.byteIdx)*8 +: 8] <= strobe.wrData;
      if (strobe.wrMask)  maskQ[int'(strobe.byteIdx)*8 +: 8]  <= strobe.wrData;
      if (strobe.wrCtrl) begin
        ctlEnQ      <= strobe.wrData[LVL_W];
        ctlMaskLvlQ <= strobe.wrData[LVL_W-1:0];
      end
    end
  end

  // recognition
  assign activeVec = (irqReq | forceQ) & ~maskQ;

  // per-level winner, higher source number wins inside a level
  assign lvlHit[0] = 1'b0;
  assign lvlWin[0] = '0;
  for (genvar lv = 1; lv < NUM_LVL; lv++) begin : g_lvl
    logic [SRC_COUNT-1:0] req;
    always_comb begin
      for (int i = 0; i < SRC_COUNT; i++)
        req[i] = activeVec[i] && (srcLvlQ[i] == LVL_W'(lv));
    end
    intc_pick #(.N(SRC_COUNT)) pick_i (
      .req (req),
      .hit (lvlHit[lv]),
      .idx (lvlWin[lv])
    );
  end

  // highest populated level
  intc_pick #(.N(NUM_LVL)) top_pick_i (
    .req (lvlHit),
    .hit (topValid),
    .idx (topLvl)
  );

  assign swIdx   = lvlWin[topLvl];
  assign irqNext = (topValid && (!ctlEnQ || topLvl > ctlMaskLvlQ)) ? topLvl : '0;

  always_ff @(posedge clk) begin
    if (!rstN) irqLevelQ <= '0;
    else       irqLevelQ <= irqNext;
  end
  assign irqLevel = irqLevelQ;

  // read mux
  always_comb begin
    rdMux = '0;
    unique case (strobe.rdSel)
      SEL_LEVEL: rdMux = DATA_W'(srcLvlQ[strobe.srcIdx]);
      SEL_FORCE: rdMux = forceQ[int'(strobe.byteIdx)*8 +: 8];
      SEL_MASK:  rdMux = maskQ[int'(strobe.byteIdx)*8 +: 8];
      SEL_CTRL:  rdMux = DATA_W'({ctlEnQ, ctlMaskLvlQ});
      SEL_ACK: begin
        if (strobe.ackLvl == '0)
          rdMux = topValid ? VEC_BASE + DATA_W'(swIdx) : VEC_SPURIOUS;
        else
          rdMux = lvlHit[strobe.ackLvl] ? VEC_BASE + DATA_W'(lvlWin[strobe.ackLvl])
                                        : VEC_SPURIOUS;
      end
      default:   rdMux = '0;
    endcase
  end

  // R6
  level_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevelQ != '0 && $past(ctlEnQ)) |-> (irqLevelQ > $past(ctlMaskLvlQ)));

  // R4
  sw_winner_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    topValid |-> (srcLvlQ[swIdx] != '0 && activeVec[swIdx]));

  // R5
  idle_level_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !topValid |=> (irqLevelQ == '0));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] irqReq,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic                 regRspValid,
  output logic                 regRspErr,
  output logic [DATA_W-1:0]    regRspData,
  output logic [LVL_W-1:0]     irqLevel
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] rdMux;

  intc_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .rdMux       (rdMux),
    .strobe      (strobe),
    .regRspValid (regRspValid),
    .regRspErr   (regRspErr),
    .regRspData  (regRspData)
  );

  intc_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .strobe   (strobe),
    .rdMux    (rdMux),
    .irqLevel (irqLevel)
  );
endmodule

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [63:0] irqReq;
  logic        wrEn, rdEn;
  logic [6:0]  addr;
  logic [7:0]  wdata;
  logic        rspValid, rspErr;
  logic [7:0]  rspData;
  logic [2:0]  irqLevel;

  intc_top dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq),
    .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr), .regWrData(wdata),
    .regRspValid(rspValid), .regRspErr(rspErr), .regRspData(rspData),
    .irqLevel(irqLevel)
  );

  // reference model state
  logic [2:0]  mLvl [64];
  logic [63:0] mForce, mMask;
  logic        mEn;
  logic [2:0]  mMaskLvl;

  typedef struct { logic [7:0] data; logic err; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic bit mActive(int i);
    return (irqReq[i] || mForce[i]) && !mMask[i] && (mLvl[i] != 3'd0);
  endfunction
  function automatic logic [7:0] mLvlVec(int n);
    logic [7:0] v = 8'h18;
    for (int i = 0; i < 64; i++) if (mActive(i) && int'(mLvl[i]) == n) v = 8'd64 + 8'(i);
    return v;
  endfunction
  function automatic int mTop();
    int t = 0;
    for (int i = 0; i < 64; i++) if (mActive(i) && int'(mLvl[i]) > t) t = int'(mLvl[i]);
    return t;
  endfunction
  function automatic logic [7:0] mSwVec();
    int t = mTop();
    return (t == 0) ? 8'h18 : mLvlVec(t);
  endfunction
  function automatic logic [2:0] mIrq();
    int t = mTop();
    if (mEn && t <= int'(mMaskLvl)) return 3'd0;
    return 3'(t);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic regRead(logic [6:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    expQ.push_back('{e, 1'b0, tag});
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic regWrite(logic [6:0] a, logic [7:0] d, string tag);
    bit err = (a >= 7'h58 && a <= 7'h5F);
    @(negedge clk);
    if (a < 7'h40)       mLvl[a[5:0]] = d[2:0];
    else if (a < 7'h48)  mForce[int'(a[2:0])*8 +: 8] = d;
    else if (a < 7'h50)  mMask[int'(a[2:0])*8 +: 8] = d;
    else if (a == 7'h50) begin mEn = d[3]; mMaskLvl = d[2:0]; end
    expQ.push_back('{8'h00, err, tag});
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setReq(logic [63:0] v);
    @(negedge clk);
    irqReq = v;
  endtask

  task automatic checkIrq(string tag);
    repeat (2) @(negedge clk);
    check(tag, 32'(irqLevel), 32'(mIrq()));
  endtask

  task automatic checkAcks(string tag);
    regRead(7'h58, mSwVec(), {tag, " R7 sw ack"});
    for (int n = 1; n < 8; n++) regRead(7'h58 + 7'(n), mLvlVec(n), {tag, " R8 level ack"});
  endtask

  // monitor: pops the scoreboard on every response
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid || rspErr) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected response actual=%0h expected=none", {rspValid, rspErr});
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " data"}, 32'(rspData), 32'(e.data));
          check({e.tag, " R11 rsp kind"}, 32'({rspValid, rspErr}), 32'({!e.err, e.err}));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqReq = '0; wrEn = 0; rdEn = 0; addr = '0; wdata = '0;
    for (int i = 0; i < 64; i++) mLvl[i] = 3'd0;
    mForce = '0; mMask = '0; mEn = 0; mMaskLvl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irqLevel", 32'(irqLevel), 0);
    check("R1 rspValid", 32'(rspValid), 0);
    check("R1 rspErr", 32'(rspErr), 0);
    regRead(7'h05, 8'h00, "R1 level reg");
    regRead(7'h43, 8'h00, "R1 force byte");
    regRead(7'h4C, 8'h00, "R1 mask byte");
    regRead(7'h50, 8'h00, "R1 ctrl");

    // R2 level registers
    regWrite(7'h02, 8'h03, "R2 wr");
    regWrite(7'h08, 8'h03, "R2 wr");
    regWrite(7'h16, 8'h03, "R2 wr");
    regWrite(7'h28, 8'hFB, "R2 wr upper bits");
    regRead(7'h28, 8'h03, "R2 readback");

    // R5/R8 several sources at one level, higher number wins
    setReq(64'h104);
    checkIrq("R5 level 3");
    regRead(7'h5B, 8'd72, "R8 tie lvl3");
    regRead(7'h58, 8'd72, "R7 sw ack");
    setReq(64'h0000_0100_0040_0504);
    regWrite(7'h0A, 8'h05, "R2 wr");
    checkIrq("R5 level 5");
    regRead(7'h5B, 8'd104, "R8 lvl3 ignores lvl5");
    regRead(7'h5D, 8'd74, "R8 lvl5");
    regRead(7'h58, 8'd74, "R7 sw ack higher level");

    // R3 mask, force
    regWrite(7'h49, 8'h04, "R3 mask src10");
    checkIrq("R3 masked src10");
    regRead(7'h58, 8'd104, "R3 sw ack after mask");
    regWrite(7'h47, 8'h80, "R4 force src63");
    checkIrq("R4 level0 forced stays idle");
    regRead(7'h58, 8'd104, "R4 level0 not in ack");
    regWrite(7'h3F, 8'h07, "R3 level src63");
    checkIrq("R3 forced source");
    regRead(7'h58, 8'd127, "R3 forced sw ack");

    // R6 level masking
    regWrite(7'h50, 8'h0F, "R6 en mask7");
    checkIrq("R6 masked out");
    regRead(7'h58, 8'd127, "R7 sw ack ignores masking");
    regWrite(7'h50, 8'h0E, "R6 en mask6");
    checkIrq("R6 above mask");
    regWrite(7'h47, 8'h00, "R3 clear force");
    regWrite(7'h50, 8'h0B, "R6 en mask3 equal");
    checkIrq("R6 equal suppressed");
    regWrite(7'h50, 8'h0A, "R6 en mask2");
    checkIrq("R6 strictly greater");
    regWrite(7'h50, 8'h07, "R6 disabled mask7");
    checkIrq("R6 disabled");

    // R9 spurious
    regRead(7'h5E, 8'h18, "R9 empty level6");
    setReq('0);
    regRead(7'h58, 8'h18, "R9 empty sw ack");

    // R10 ack writes
    setReq(64'h100);
    regWrite(7'h5B, 8'hFF, "R10 ack write err");
    regWrite(7'h58, 8'h00, "R10 sw ack write err");
    checkIrq("R10 no state change");
    regRead(7'h5B, 8'd72, "R10 ack unchanged");

    // R12 unmapped
    regRead(7'h53, 8'h00, "R12 unmapped read");
    regRead(7'h7F, 8'h00, "R12 unmapped read high");
    regWrite(7'h60, 8'hFF, "R12 unmapped write");
    checkIrq("R12 write ignored");
    regRead(7'h50, 8'h07, "R12 ctrl unchanged");

    // randomised patterns
    for (int it = 0; it < 12; it++) begin
      for (int s = 0; s < 64; s++) regWrite(7'(s), 8'($urandom_range(0, 7)), "R2 rand wr");
      for (int k = 0; k < 8; k++) regWrite(7'h48 + 7'(k), 8'($urandom) & 8'($urandom), "R3 rand mask");
      for (int k = 0; k < 8; k++) regWrite(7'h40 + 7'(k), 8'($urandom) & 8'($urandom) & 8'($urandom), "R3 rand force");
      regWrite(7'h50, 8'($urandom_range(0, 15)), "R6 rand ctrl");
      setReq({$urandom, $urandom} & {$urandom, $urandom});
      checkIrq("R5 R6 rand irqLevel");
      checkAcks("rand");
    end

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 32'(expQ.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule